// File: doc/BRIEF.md
# Predicate Mask Boolean Unit

This unit carries out bitwise logic on predicate masks. It holds sixteen 64-bit mask registers and sixteen one-bit boolean registers. A qualified 32-bit instruction word names an operator, an operand class and three register indices. The unit reads one or two sources, computes the result and fully overwrites the destination on the next rising clock edge. A mask operation treats its operands as flat bit vectors: there is no lane width, no sign and no saturation.

The instruction word is a fixed selector template with the three register-index fields laid over it. The decoder compares only the bits that no field covers. Bit 16 is both the top bit of the destination index and the low bit of the class byte, and this bit tells the mask NOT apart from the single-bit NOT. A word that matches no legal pattern writes nothing and raises an illegal flag. A side load port puts initial values into either register file. Two mask read ports and one bit read port give combinational access to the stored state.

Top module: `pred_bool_alu`

## Requirements
- R1: After reset, all sixteen mask registers and all sixteen bit registers read zero, and `illegal` is low.
- R2: Selector byte [31:24] = 0x70 with class bits [23:17] = 0x08 writes first & second. Selector 0xB0 with class 0x08 writes first | second. Selector 0xD0 with class bits [23:17] = 0x00 writes first ^ second. All three are plain 64-bit bitwise operations on mask registers.
- R3: Selector 0xA0 with class bits [23:17] = 0x00 writes the mask first & ~second. Selector 0xC0 with class 0x00 writes the mask first | ~second.
- R4: Selector 0xE0 with class byte 0x10 (bits [23:17] = 0x08 and bit 16 = 0, so the destination is 0..7) writes the mask ~first. The second-source field has no effect on the result.
- R5: The destination index is taken from bits [16:13], the first source from [3:0] and the second source from [11:8]. The result appears on the read ports after the first rising edge that follows the valid word. No other register changes. When the destination equals a source, the old source value is used.
- R6: Selector 0xA0 with class bits [23:17] = 0x08 writes the single-bit register first & ~second. Selector 0xC0 with class 0x08 writes the single-bit register first | ~second. Both use the bit file with the same index fields.
- R7: Selector 0xE0 with class byte 0x11 (bits [23:17] = 0x08 and bit 16 = 1, so the destination is 8..15) writes a 1 to the bit register exactly when the first-source bit is 0.
- R8: A valid word is illegal when bit 12 or bits [7:4] are nonzero, or when its selector and class bits match none of the patterns in R2 to R7. An illegal word writes nothing, and `illegal` is high in the following cycle.
- R9: While `instValid` is low, the instruction word writes nothing and `illegal` stays low.
- R10: A load writes `ldMaskData` or `ldBitData` into register `ldIdx` on the next edge. If an instruction writes the same register of the same file in that cycle, the instruction result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Qualifies instWord |
| instWord | input | 32 | Instruction word |
| ldMaskEn | input | 1 | Load enable for the mask file |
| ldBitEn | input | 1 | Load enable for the bit file |
| ldIdx | input | 4 | Register index for a load |
| ldMaskData | input | 64 | Mask load value |
| ldBitData | input | 1 | Bit load value |
| rdMaskIdxA | input | 4 | Mask read port A index |
| rdMaskDataA | output | 64 | Mask read port A data |
| rdMaskIdxB | input | 4 | Mask read port B index |
| rdMaskDataB | output | 64 | Mask read port B data |
| rdBitIdx | input | 4 | Bit read port index |
| rdBitData | output | 1 | Bit read port data |
| illegal | output | 1 | High for one cycle after an illegal valid word |

## Verification
The bench runs the complementing operators with operands whose nibbles do not coincide. A design that inverted the wrong source, or left out the inversion, returns a visibly different 64-bit pattern. It places the destination index in the high field and uses distinct source indices, so a design that decoded the fields in left-to-right order would write the wrong register. It checks the two NOT forms on either side of bit 16 and puts a nonzero second-source field on the mask NOT. A decoder that ignored the class bit, or read the stray source, shows up here. It also sends words with stray fixed bits and mismatched selector/class pairs, which a lax decoder would execute. It sends an in-place XOR, which a forwarding error would corrupt, and a same-register load/instruction collision that a wrong write priority would resolve the other way.

// File: rtl/pbool_pkg.sv
package pbool_pkg;
  localparam int REG_CNT = 16;
  localparam int IDX_W   = $clog2(REG_CNT);

  // operator selector byte, bits [31:24]
  localparam logic [7:0] SEL_AND  = 8'h70;
  localparam logic [7:0] SEL_OR   = 8'hB0;
  localparam logic [7:0] SEL_XOR  = 8'hD0;
  localparam logic [7:0] SEL_ANDN = 8'hA0;
  localparam logic [7:0] SEL_ORN  = 8'hC0;
  localparam logic [7:0] SEL_NOT  = 8'hE0;

  // class byte bits [23:17]; bit 16 doubles as the destination MSB
  localparam logic [6:0] CLS_HI = 7'h08;  // 0x10 / 0x11
  localparam logic [6:0] CLS_LO = 7'h00;  // 0x00

  typedef enum logic [2:0] {
    OP_AND, OP_OR, OP_XOR, OP_ANDN, OP_ORN, OP_NOT
  } op_e;

  typedef struct packed {
    logic             wrMask;
    logic             wrBit;
    logic             illegal;
    op_e              op;
    logic [IDX_W-1:0] dst;
    logic [IDX_W-1:0] srcA;
    logic [IDX_W-1:0] srcB;
  } strobe_t;
endpackage

// File: rtl/pbool_decode.sv
module pbool_decode
  import pbool_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instValid,
  input  logic [31:0] instWord,
  output strobe_t     strb
);
  logic [7:0] selByte;
  logic [6:0] clsBits;
  logic       fixedOk;
  logic       isMask;
  logic       isBit;
  op_e        opSel;

  assign selByte = instWord[31:24];
  assign clsBits = instWord[23:17];
  // bits of the template not covered by any register field must be zero
  assign fixedOk = (instWord[12] == 1'b0) && (instWord[7:4] == 4'h0);

  always_comb begin
    isMask = 1'b0;
    isBit  = 1'b0;
    opSel  = OP_AND;
    unique case (selByte)
      SEL_AND: begin
        opSel  = OP_AND;
        isMask = (clsBits == CLS_HI);
      end
      SEL_OR: begin
        opSel  = OP_OR;
        isMask = (clsBits == CLS_HI);
      end
      SEL_XOR: begin
        opSel  = OP_XOR;
        isMask = (clsBits == CLS_LO);
      end
      SEL_ANDN: begin
        opSel  = OP_ANDN;
        isMask = (clsBits == CLS_LO);
        isBit  = (clsBits == CLS_HI);
      end
      SEL_ORN: begin
        opSel  = OP_ORN;
        isMask = (clsBits == CLS_LO);
        isBit  = (clsBits == CLS_HI);
      end
      SEL_NOT: begin
        opSel  = OP_NOT;
        isMask = (clsBits == CLS_HI) && !instWord[16];
        isBit  = (clsBits == CLS_HI) &&  instWord[16];
      end
      default: begin
        opSel = OP_AND;
      end
    endcase
  end

  always_comb begin
    strb.op      = opSel;
    strb.dst     = instWord[16:13];
    strb.srcA    = instWord[3:0];
    strb.srcB    = instWord[11:8];
    strb.wrMask  = instValid && fixedOk && isMask;
    strb.wrBit   = instValid && fixedOk && isBit;
    strb.illegal = instValid && !(fixedOk && (isMask || isBit));
  end

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrMask, strb.wrBit, strb.illegal}));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instValid |-> !(strb.wrMask || strb.wrBit || strb.illegal));
endmodule

// File: rtl/pbool_datapath.sv
module pbool_datapath
  import pbool_pkg::*;
#(
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              ldMaskEn,
  input  logic              ldBitEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [MASK_W-1:0] ldMaskData,
  input  logic              ldBitData,
  input  logic [IDX_W-1:0]  rdMaskIdxA,
  output logic [MASK_W-1:0] rdMaskDataA,
  input  logic [IDX_W-1:0]  rdMaskIdxB,
  output logic [MASK_W-1:0] rdMaskDataB,
  input  logic [IDX_W-1:0]  rdBitIdx,
  output logic              rdBitData,
  output logic              illegal
);
  logic [MASK_W-1:0] maskQ [REG_CNT];
  logic              bitQ  [REG_CNT];
  logic [MASK_W-1:0] opA, opB, maskRes;
  logic              bitA, bitB, bitRes;
  logic              illegalQ;

  assign opA  = maskQ[strb.srcA];
  assign opB  = maskQ[strb.srcB];
  assign bitA = bitQ[strb.srcA];
  assign bitB = bitQ[strb.srcB];

  always_comb begin
    unique case (strb.op)
      OP_AND:  maskRes = opA & opB;
      OP_OR:   maskRes = opA | opB;
      OP_XOR:  maskRes = opA ^ opB;
      OP_ANDN: maskRes = opA & ~opB;
      OP_ORN:  maskRes = opA | ~opB;
      OP_NOT:  maskRes = ~opA;
      default: maskRes = '0;
    endcase
  end

  always_comb begin
    unique case (strb.op)
      OP_ANDN: bitRes = bitA & ~bitB;
      OP_ORN:  bitRes = bitA | ~bitB;
      OP_NOT:  bitRes = ~bitA;
      default: bitRes = 1'b0;
    endcase
  end

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        maskQ[g] <= '0;
      end else if (strb.wrMask && strb.dst == IDX_W'(g)) begin
        maskQ[g] <= maskRes;
      end else if (ldMaskEn && ldIdx == IDX_W'(g)) begin
        maskQ[g] <= ldMaskData;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitQ[g] <= 1'b0;
      end else if (strb.wrBit && strb.dst == IDX_W'(g)) begin
        bitQ[g] <= bitRes;
      end else if (ldBitEn && ldIdx == IDX_W'(g)) begin
        bitQ[g] <= ldBitData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalQ <= 1'b0;
    else       illegalQ <= strb.illegal;
  end

  assign rdMaskDataA = maskQ[rdMaskIdxA];
  assign rdMaskDataB = maskQ[rdMaskIdxB];
  assign rdBitData   = bitQ[rdBitIdx];
  assign illegal     = illegalQ;

  // R4
  mask_not_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMask && strb.op == OP_NOT) |=>
      maskQ[$past(strb.dst)] == ~$past(maskQ[strb.srcA]));

  // R6
  bit_andn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrBit && strb.op == OP_ANDN) |=>
      bitQ[$past(strb.dst)] == ($past(bitQ[strb.srcA]) & ~$past(bitQ[strb.srcB])));

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.illegal && !(ldMaskEn && ldIdx == strb.dst)) |=>
      maskQ[$past(strb.dst)] == $past(maskQ[strb.dst]));

  // R10
  load_yield_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrMask && ldMaskEn && ldIdx == strb.dst && strb.op == OP_XOR) |=>
      maskQ[$past(strb.dst)] == ($past(maskQ[strb.srcA]) ^ $past(maskQ[strb.srcB])));
endmodule

// File: rtl/pred_bool_alu.sv
module pred_bool_alu
  import pbool_pkg::*;
#(
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [31:0]       instWord,
  input  logic              ldMaskEn,
  input  logic              ldBitEn,
  input  logic [IDX_W-1:0]  ldIdx,
  input  logic [MASK_W-1:0] ldMaskData,
  input  logic              ldBitData,
  input  logic [IDX_W-1:0]  rdMaskIdxA,
  output logic [MASK_W-1:0] rdMaskDataA,
  input  logic [IDX_W-1:0]  rdMaskIdxB,
  output logic [MASK_W-1:0] rdMaskDataB,
  input  logic [IDX_W-1:0]  rdBitIdx,
  output logic              rdBitData,
  output logic              illegal
);
  strobe_t strb;

  pbool_decode u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .instValid (instValid),
    .instWord  (instWord),
    .strb      (strb)
  );

  pbool_datapath #(.MASK_W(MASK_W)) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .ldMaskEn    (ldMaskEn),
    .ldBitEn     (ldBitEn),
    .ldIdx       (ldIdx),
    .ldMaskData  (ldMaskData),
    .ldBitData   (ldBitData),
    .rdMaskIdxA  (rdMaskIdxA),
    .rdMaskDataA (rdMaskDataA),
    .rdMaskIdxB  (rdMaskIdxB),
    .rdMaskDataB (rdMaskDataB),
    .rdBitIdx    (rdBitIdx),
    .rdBitData   (rdBitData),
    .illegal     (illegal)
  );
endmodule

// File: tb/pred_bool_alu_tb.sv
module pred_bool_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instValid = 1'b0;
  logic [31:0] instWord = '0;
  logic        ldMaskEn = 1'b0;
  logic        ldBitEn = 1'b0;
  logic [3:0]  ldIdx = '0;
  logic [63:0] ldMaskData = '0;
  logic        ldBitData = 1'b0;
  logic [3:0]  rdMaskIdxA = '0;
  logic [63:0] rdMaskDataA;
  logic [3:0]  rdMaskIdxB = '0;
  logic [63:0] rdMaskDataB;
  logic [3:0]  rdBitIdx = '0;
  logic        rdBitData;
  logic        illegal;

  pred_bool_alu u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        isBit;
    logic [3:0]  idx;
    logic [63:0] val;
    logic [3:0]  idxB;
    logic [63:0] valB;
    logic        ill;
  } item_t;

  item_t expQ[$];
  string tagQ[$];
  logic [63:0] mM [16];
  logic        bM [16];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  function automatic logic [31:0] mk(input logic [7:0] sel, input logic [6:0] c7,
                                     input logic [3:0] d, input logic [3:0] a,
                                     input logic [3:0] b);
    return {sel, c7, d, 1'b0, b, 4'h0, a};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one cycle of stimulus; model updated here, expectation queued after the edge
  task automatic cyc(input logic v, input logic [31:0] w, input logic lm, input logic lb,
                     input logic [3:0] li, input logic [63:0] ld, input logic ldb,
                     input string tag);
    logic [7:0] sel;
    logic [6:0] c;
    logic [3:0] d, a, b;
    logic fixed, isM, isB;
    logic [63:0] r;
    logic rb;
    item_t it;
    @(negedge clk);
    instValid = v; instWord = w; ldMaskEn = lm; ldBitEn = lb;
    ldIdx = li; ldMaskData = ld; ldBitData = ldb;
    sel = w[31:24]; c = w[23:17]; d = w[16:13]; a = w[3:0]; b = w[11:8];
    fixed = (w[12] == 1'b0) && (w[7:4] == 4'h0);
    isM = 1'b0; isB = 1'b0; r = '0; rb = 1'b0;
    if (sel == 8'h70 && c == 7'h08) begin isM = 1; r = mM[a] & mM[b]; end
    if (sel == 8'hB0 && c == 7'h08) begin isM = 1; r = mM[a] | mM[b]; end
    if (sel == 8'hD0 && c == 7'h00) begin isM = 1; r = mM[a] ^ mM[b]; end
    if (sel == 8'hA0 && c == 7'h00) begin isM = 1; r = mM[a] & ~mM[b]; end
    if (sel == 8'hC0 && c == 7'h00) begin isM = 1; r = mM[a] | ~mM[b]; end
    if (sel == 8'hE0 && c == 7'h08 && !d[3]) begin isM = 1; r = ~mM[a]; end
    if (sel == 8'hA0 && c == 7'h08) begin isB = 1; rb = bM[a] & ~bM[b]; end
    if (sel == 8'hC0 && c == 7'h08) begin isB = 1; rb = bM[a] | ~bM[b]; end
    if (sel == 8'hE0 && c == 7'h08 && d[3]) begin isB = 1; rb = (bM[a] == 1'b0); end
    isM = isM && fixed && v;
    isB = isB && fixed && v;
    if (lm) mM[li] = ld;
    if (lb) bM[li] = ldb;
    if (isM) mM[d] = r;
    if (isB) bM[d] = rb;
    it.isBit = isB;
    it.idx = d;
    it.val = isB ? {63'b0, bM[d]} : mM[d];
    it.idxB = a;
    it.valB = mM[a];
    it.ill = v && !(isM || isB);
    @(posedge clk);
    if (tag != "") begin
      expQ.push_back(it);
      tagQ.push_back(tag);
    end
  endtask

  task automatic issue(input logic [31:0] w, input string tag);
    cyc(1'b1, w, 1'b0, 1'b0, 4'h0, 64'h0, 1'b0, tag);
  endtask

  task automatic loadM(input logic [3:0] i, input logic [63:0] v);
    cyc(1'b0, 32'h0, 1'b1, 1'b0, i, v, 1'b0, "");
  endtask

  task automatic loadB(input logic [3:0] i, input logic v);
    cyc(1'b0, 32'h0, 1'b0, 1'b1, i, 64'h0, v, "");
  endtask

  task automatic drain();
    cyc(1'b0, 32'h0, 1'b0, 1'b0, 4'h0, 64'h0, 1'b0, "");
    wait (expQ.size() == 0);
    @(negedge clk);
    #2;
  endtask

  // monitor: pops one expectation per cycle and compares at the read ports
  initial begin
    item_t it;
    string tag;
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        tag = tagQ.pop_front();
        rdMaskIdxA = it.idx;
        rdBitIdx = it.idx;
        rdMaskIdxB = it.idxB;
        #1;
        chk({tag, " illegal"}, {63'b0, illegal}, {63'b0, it.ill});
        if (it.isBit) chk({tag, " bit dst"}, {63'b0, rdBitData}, it.val);
        else          chk({tag, " mask dst"}, rdMaskDataA, it.val);
        chk({tag, " src unchanged"}, rdMaskDataB, it.valB);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    item_t it;
    for (int i = 0; i < 16; i++) begin mM[i] = '0; bM[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: reset state of both files
    for (int i = 0; i < 16; i++) begin
      it = '0; it.idx = 4'(i); it.idxB = 4'(i);
      expQ.push_back(it); tagQ.push_back("R1");
      it.isBit = 1'b1;
      expQ.push_back(it); tagQ.push_back("R1");
    end
    wait (expQ.size() == 0);
    @(negedge clk);

    loadM(4'd1, 64'hF0F0F0F0F0F0F0F0);
    loadM(4'd2, 64'h00FF00FF00FF00FF);
    // R2 / R3 / R5: destination field above the source fields
    issue(mk(8'h70, 7'h08, 4'd3, 4'd1, 4'd2), "R2 and");
    issue(mk(8'hB0, 7'h08, 4'd12, 4'd1, 4'd2), "R2 or");
    issue(mk(8'hD0, 7'h00, 4'd5, 4'd1, 4'd2), "R2 xor");
    issue(mk(8'hA0, 7'h00, 4'd6, 4'd1, 4'd2), "R3 andnot");
    issue(mk(8'hC0, 7'h00, 4'd13, 4'd1, 4'd2), "R3 ornot");
    issue(mk(8'hC0, 7'h00, 4'd14, 4'd2, 4'd1), "R3 ornot swapped");
    // R4: stray second-source field
    issue(mk(8'hE0, 7'h08, 4'd7, 4'd1, 4'd15), "R4 not");
    drain();
    rdMaskIdxA = 4'd3; #1;
    chk("R2 and const", rdMaskDataA, 64'h00F000F000F000F0);
    rdMaskIdxA = 4'd6; #1;
    chk("R3 andnot const", rdMaskDataA, 64'hF000F000F000F000);
    rdMaskIdxA = 4'd13; #1;
    chk("R3 ornot const", rdMaskDataA, 64'hFFF0FFF0FFF0FFF0);
    rdMaskIdxA = 4'd7; #1;
    chk("R4 not const", rdMaskDataA, 64'h0F0F0F0F0F0F0F0F);

    // R5: in-place and back-to-back dependency
    loadM(4'd9, 64'h0123456789ABCDEF);
    issue(mk(8'hD0, 7'h00, 4'd9, 4'd9, 4'd9), "R5 inplace xor");
    issue(mk(8'hE0, 7'h08, 4'd4, 4'd9, 4'd0), "R5 dependent not");
    issue(mk(8'hA0, 7'h00, 4'd8, 4'd4, 4'd1), "R5 chain andnot");

    // R6 / R7: single-bit forms
    loadB(4'd1, 1'b1);
    loadB(4'd2, 1'b0);
    issue(mk(8'hA0, 7'h08, 4'd3, 4'd1, 4'd2), "R6 andnot 1,0");
    issue(mk(8'hA0, 7'h08, 4'd4, 4'd1, 4'd1), "R6 andnot 1,1");
    issue(mk(8'hA0, 7'h08, 4'd5, 4'd2, 4'd2), "R6 andnot 0,0");
    issue(mk(8'hC0, 7'h08, 4'd6, 4'd2, 4'd1), "R6 ornot 0,1");
    issue(mk(8'hC0, 7'h08, 4'd7, 4'd2, 4'd2), "R6 ornot 0,0");
    issue(mk(8'hC0, 7'h08, 4'd10, 4'd1, 4'd1), "R6 ornot 1,1");
    issue(mk(8'hE0, 7'h08, 4'd9, 4'd2, 4'd0), "R7 not of 0");
    issue(mk(8'hE0, 7'h08, 4'd11, 4'd1, 4'd0), "R7 not of 1");

    // R8: illegal words write nothing
    issue(mk(8'h70, 7'h00, 4'd3, 4'd1, 4'd2), "R8 and wrong class");
    issue(mk(8'hD0, 7'h08, 4'd5, 4'd1, 4'd2), "R8 xor wrong class");
    issue(mk(8'hE0, 7'h00, 4'd7, 4'd2, 4'd0), "R8 not wrong class");
    issue(mk(8'h55, 7'h08, 4'd3, 4'd2, 4'd2), "R8 unknown selector");
    issue(mk(8'h70, 7'h08, 4'd3, 4'd2, 4'd2) | 32'h0000_1000, "R8 bit12 set");
    issue(mk(8'hB0, 7'h08, 4'd12, 4'd2, 4'd2) | 32'h0000_0040, "R8 bits7:4 set");

    // R9: word present but not qualified
    cyc(1'b0, mk(8'h70, 7'h08, 4'd3, 4'd2, 4'd2), 1'b0, 1'b0, 4'h0, 64'h0, 1'b0, "R9 idle");

    // R10: load and instruction together
    cyc(1'b1, mk(8'hD0, 7'h00, 4'd10, 4'd1, 4'd2), 1'b1, 1'b0, 4'd10,
        64'hDEADBEEFDEADBEEF, 1'b0, "R10 same reg");
    cyc(1'b1, mk(8'h70, 7'h08, 4'd11, 4'd1, 4'd2), 1'b1, 1'b0, 4'd15,
        64'h5555AAAA5555AAAA, 1'b0, "R10 other reg");
    drain();
    rdMaskIdxA = 4'd15; #1;
    chk("R10 load kept", rdMaskDataA, 64'h5555AAAA5555AAAA);
    rdMaskIdxA = 4'd10; #1;
    chk("R10 instr wins", rdMaskDataA, 64'hF00FF00FF00FF00F);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule